// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches an n-bit data word carried in dual-rail form and reports when the word is complete and when it has gone back to the spacer. Each bit travels on a pair of rails. The pair 00 is the spacer, and one high rail marks the bit as computed. From these pairs the block forms three signals:

- An all-valid signal, high when every bit is computed.
- An any-valid signal, high while at least one bit is still computed.
- A handshake output. It is a two-input C-element of the other two, with feedback.

The handshake goes high once the whole word has arrived. It stays high until every bit has returned to the spacer, and only then goes low. A four-phase sender can use this single wire as its acknowledge.

This is a cycle-based model. All outputs are registered with the same one-cycle latency. The block also returns the decoded word, which is valid while all-valid is high. A pair with both rails high is illegal and latches an error flag until reset.

Top module: `dr_completion_detect`

## Requirements
- R1: Pair encoding is {rail_hi[i], rail_lo[i]}: 00 is spacer, 01 is value 0, 10 is value 1, 11 is illegal. A bit counts as acknowledged when either of its rails is high, and this includes 11.
- R2: all_valid_o equals the AND of all bit acknowledges sampled at the previous rising clock edge.
- R3: any_valid_o equals the OR of all bit acknowledges sampled at the previous edge. It rises when the first bit arrives and drops only after the last bit is back at spacer.
- R4: handshake_o rises in the same cycle as all_valid_o goes high. While all_valid_o is high, handshake_o is high.
- R5: Once set, handshake_o stays high while any_valid_o is high, even after all_valid_o has dropped. A partly arrived word never sets it.
- R6: handshake_o is low in every cycle in which any_valid_o is low.
- R7: A pair equal to 11 on any bit sets illegal_o at the next edge. illegal_o then stays high until rst_n is asserted.
- R8: While all_valid_o is high, word_o holds the decoded value of each bit (1 for pair 10, 0 for pair 01).
- R9: While rst_n is low, all_valid_o, any_valid_o, handshake_o and illegal_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_lo | input | WIDTH | Low rail of each bit (value-0 rail) |
| rail_hi | input | WIDTH | High rail of each bit (value-1 rail) |
| all_valid_o | output | 1 | Registered: every bit computed |
| any_valid_o | output | 1 | Registered: at least one bit computed |
| handshake_o | output | 1 | C-element output with hysteresis |
| word_o | output | WIDTH | Decoded word, valid while all_valid_o is high |
| illegal_o | output | 1 | Sticky flag for an illegal 11 pair |

## Verification
Two things can happen at the same edge: the set term of the C-element can fire, and the hold path can release. This occurs when the last pending bit of one word arrives, or when the last bit of a word departs. The cases are provoked with a directed single late arrival, a single late departure, and fully simultaneous arrival and departure. They are also provoked by random per-cycle arrival and departure orders. In every cycle, each output is compared against a bench reference model of the set/hold equation. The model also records which path applied, so that each mismatch is reported against the requirement for setting, holding or clearing.

// File: rtl/dr_cd_pkg.sv
package dr_cd_pkg;
  // Pair code as {hi rail, lo rail}
  typedef enum logic [1:0] {
    PAIR_SPACER = 2'b00,
    PAIR_ZERO   = 2'b01,
    PAIR_ONE    = 2'b10,
    PAIR_BAD    = 2'b11
  } pair_e;
endpackage

// File: rtl/dr_rail_decode.sv
module dr_rail_decode
  import dr_cd_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] lo_i,
  input  logic [WIDTH-1:0] hi_i,
  output logic [WIDTH-1:0] ack_o,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] bad_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    pair_e pair;
    assign pair      = pair_e'({hi_i[i], lo_i[i]});
    assign ack_o[i]  = (pair != PAIR_SPACER);
    assign data_o[i] = (pair == PAIR_ONE);
    assign bad_o[i]  = (pair == PAIR_BAD);
  end
endmodule

// File: rtl/dr_reduce.sv
module dr_reduce #(
  parameter int WIDTH  = 32,
  parameter bit USE_AND = 1'b1
) (
  input  logic [WIDTH-1:0] x_i,
  output logic             y_o
);
  if (USE_AND) begin : g_and
    assign y_o = &x_i;
  end else begin : g_or
    assign y_o = |x_i;
  end
endmodule

// File: rtl/dr_c_element.sv
module dr_c_element (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic keep_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = set_i | (keep_i & q_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dr_completion_detect.sv
module dr_completion_detect
  import dr_cd_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rail_lo,
  input  logic [WIDTH-1:0] rail_hi,
  output logic             all_valid_o,
  output logic             any_valid_o,
  output logic             handshake_o,
  output logic [WIDTH-1:0] word_o,
  output logic             illegal_o
);
  logic [WIDTH-1:0] ack, data, bad;
  logic             all_c, any_c;

  dr_rail_decode #(.WIDTH(WIDTH)) u_decode (
    .lo_i(rail_lo), .hi_i(rail_hi),
    .ack_o(ack), .data_o(data), .bad_o(bad)
  );

  dr_reduce #(.WIDTH(WIDTH), .USE_AND(1'b1)) u_all (.x_i(ack), .y_o(all_c));
  dr_reduce #(.WIDTH(WIDTH), .USE_AND(1'b0)) u_any (.x_i(ack), .y_o(any_c));

  dr_c_element u_celem (
    .clk(clk), .rst_n(rst_n),
    .set_i(all_c), .keep_i(any_c), .q_o(handshake_o)
  );

  logic             all_q, any_q, bad_q;
  logic             all_d, any_d, bad_d;
  logic [WIDTH-1:0] word_q, word_d;
  logic             word_en;

  always_comb begin
    all_d   = all_c;
    any_d   = any_c;
    bad_d   = bad_q | (|bad);
    word_en = all_c;
    word_d  = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_q <= 1'b0;
      any_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      all_q <= all_d;
      any_q <= any_d;
      bad_q <= bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign all_valid_o = all_q;
  assign any_valid_o = any_q;
  assign illegal_o   = bad_q;
  assign word_o      = word_q;
endmodule

// File: rtl/dr_completion_detect_chk.sv
module dr_completion_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic all_valid_o,
  input logic any_valid_o,
  input logic handshake_o,
  input logic illegal_o
);
  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    all_valid_o |-> handshake_o);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_valid_o && $past(handshake_o)) |-> handshake_o);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_valid_o |-> !handshake_o);

  p_all_in_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
    all_valid_o |-> any_valid_o);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> illegal_o);
endmodule

bind dr_completion_detect dr_completion_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .all_valid_o(all_valid_o), .any_valid_o(any_valid_o),
  .handshake_o(handshake_o), .illegal_o(illegal_o)
);

// File: tb/dr_completion_detect_bench.sv
`timescale 1ns/1ps
module dr_completion_detect_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] rail_lo = '0, rail_hi = '0;
  logic all_valid_o, any_valid_o, handshake_o, illegal_o;
  logic [W-1:0] word_o;

  always #2.5 clk = ~clk;

  dr_completion_detect #(.WIDTH(W)) u_dr_completion_detect (
    .clk(clk), .rst_n(rst_n), .rail_lo(rail_lo), .rail_hi(rail_hi),
    .all_valid_o(all_valid_o), .any_valid_o(any_valid_o),
    .handshake_o(handshake_o), .word_o(word_o), .illegal_o(illegal_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic m_all, m_any, m_hs, m_bad, m_prev_hs;
  logic [W-1:0] m_word;

  function automatic logic [W-1:0] f_ack(logic [W-1:0] lo, logic [W-1:0] hi);
    return lo | hi;   // R1
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string hs_tag;
    chk("R2 all_valid", 64'(all_valid_o), 64'(m_all));
    chk("R3 any_valid", 64'(any_valid_o), 64'(m_any));
    if (m_hs && !m_prev_hs)      hs_tag = "R4 handshake set";
    else if (m_hs)               hs_tag = "R5 handshake hold";
    else                         hs_tag = "R6 handshake low";
    chk(hs_tag, 64'(handshake_o), 64'(m_hs));
    chk("R7 illegal", 64'(illegal_o), 64'(m_bad));
    if (m_all) chk("R8 R1 word", 64'(word_o), 64'(m_word));
  endtask

  task automatic drive(logic [W-1:0] lo, logic [W-1:0] hi);
    logic [W-1:0] a;
    @(negedge clk);
    rail_lo = lo;
    rail_hi = hi;
    @(posedge clk);
    a = f_ack(lo, hi);
    m_prev_hs = m_hs;
    m_hs  = (&a) | ((|a) & m_hs);
    m_all = &a;
    m_any = |a;
    m_bad = m_bad | (|(lo & hi));
    if (&a) m_word = hi;
    #1;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 reset all_valid", 64'(all_valid_o), 64'd0);
    chk("R9 reset any_valid", 64'(any_valid_o), 64'd0);
    chk("R9 reset handshake", 64'(handshake_o), 64'd0);
    chk("R9 reset illegal", 64'(illegal_o), 64'd0);
    m_all = 0; m_any = 0; m_hs = 0; m_bad = 0; m_prev_hs = 0;
    rail_lo = '0; rail_hi = '0;
    rst_n = 1'b1;
  endtask

  // Random four-phase wave: bits arrive and depart in random order
  task automatic wave(int prob);
    logic [W-1:0] val, arrived, lo, hi;
    val = $urandom;
    arrived = '0;
    while (arrived != '1) begin
      for (int i = 0; i < W; i++)
        if (($urandom % 100) < prob) arrived[i] = 1'b1;
      lo = arrived & ~val; hi = arrived & val;
      drive(lo, hi);
    end
    repeat ($urandom % 3) drive(lo, hi);
    while (arrived != '0) begin
      for (int i = 0; i < W; i++)
        if (($urandom % 100) < prob) arrived[i] = 1'b0;
      lo = arrived & ~val; hi = arrived & val;
      drive(lo, hi);
    end
    drive('0, '0);
  endtask

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd20240611));
    do_reset();
    drive('0, '0);                         // quiescent, R6
    // all bits arrive together, then return together
    v = 32'hA5C3_0F71;
    drive(~v, v);                          // R4
    drive(~v, v);                          // R5 steady
    drive('0, '0);                         // R6
    // single late bit arrival and late return
    v = 32'h1234_5678;
    drive(~v & 32'h7FFF_FFFF, v & 32'h7FFF_FFFF);  // R5: no set yet
    drive(~v & 32'h7FFF_FFFF, v & 32'h7FFF_FFFF);
    drive(~v, v);                          // R4: last bit completes
    drive(~v & 32'h0000_0100, v & 32'h0000_0100);  // R5: one bit held
    drive(~v & 32'h0000_0100, v & 32'h0000_0100);
    drive('0, '0);                         // R6: last departure
    drive('0, '0);
    // value encoding extremes, R1 R8
    drive('1, '0);
    drive('0, '0);
    drive('0, '1);
    drive('0, '0);
    for (int k = 0; k < 60; k++) wave(10 + ($urandom % 60));
    // illegal pair, R7
    drive(32'h0000_0010, 32'h0000_0010);
    drive('0, '0);
    wave(40);
    do_reset();                            // clears R7 flag
    drive('0, '0);
    wave(50);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule